// File: doc/BRIEF.md
# Twelve-Bit Accumulator Processor Core

This block is a small accumulator machine. Data words are 12-bit two's complement. Each instruction word holds a 4-bit operation code in bits 11:8 and an 8-bit address in bits 7:0. The core holds five registers: a program counter, a memory address register, a memory data register, an instruction address latch and the accumulator. It also keeps positive and zero flags that are loaded in the same cycle as the accumulator.

Every instruction runs as a fixed sequence of single-cycle data-path steps. Each step passes one value through a shared adder and onto the result bus. Memory sits outside the core. When `mem_rd` is high, the memory samples `mem_addr` at the clock edge and presents the word on `mem_rdata` for the whole of the next cycle. The core registers that word at the end of that wait cycle. When `mem_wr` is high, the memory writes `mem_wdata` at `mem_addr` on the clock edge. When `mem_pd` is high, the memory presents its highest installed address on `mem_rdata` in the next cycle.

Values enter the core through a valid/ready handshake and leave it on a one-cycle strobe. The core reports a halt and a sticky arithmetic machine check.

Top module: `acc12_core`

## Requirements
- R1: After reset is released, the core spends one cycle with `mem_pd` high and then one wait cycle. In the third cycle it writes the returned top address, as a zero-extended word, to the location with that same address. The first fetch follows at address 0. While reset is held, `halted`, `mcheck` and `out_valid` are low, and the accumulator is reset to zero.
- R2: Every instruction starts with three cycles. Cycle 1 reads at the program counter. Cycle 2 waits while the program counter increments. Cycle 3 loads the instruction, with the opcode in bits 11:8 and the address in bits 7:0.
- R3: ADD (opcode 1) and SUB (opcode 2) read the operand at the instruction address in cycle 4 and write the accumulator in cycle 6. SUB computes accumulator minus operand. A true result outside -2048..+2047 still leaves the truncated 12-bit value in the accumulator and raises `mcheck`, which then stays high until reset.
- R4: LDA (opcode 5) reads the operand in cycle 4 and copies it into the accumulator in cycle 6.
- R5: STO (opcode 3) writes the accumulator to the instruction address in cycle 5 and ends after cycle 6.
- R6: BR (opcode 6) loads the instruction address into the program counter in cycle 4 and ends there.
- R7: BRZ (opcode 7) behaves like BR when the zero flag is set. Otherwise it ends after cycle 3 and execution continues in sequence.
- R8: BRP (opcode 8) behaves like BR when the accumulator's sign bit is 0, which includes a zero accumulator. Otherwise it ends after cycle 3.
- R9: Input is instruction word 0x901. From cycle 4 the core holds `in_ready` high until `in_valid` is seen. In that cycle it loads `in_data` into the accumulator and ends the instruction. `in_valid` has no effect at any other time.
- R10: Output is instruction word 0x902. In cycle 4 `out_valid` is high for exactly one cycle and `out_data` carries the accumulator. The instruction ends there.
- R11: Opcode 0 ends after cycle 3. From the next cycle `halted` stays high and no memory, input or output activity occurs until reset.
- R12: Opcodes 4 and 10 to 15, and opcode 9 with any address other than 0x01 or 0x02, end after cycle 3 with no effect.
- R13: Both branch flags reflect the last value written to the accumulator. They are not changed by stores, branches or program counter increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | ADDR_W | Memory address for a read or write strobe |
| mem_rd | output | 1 | Read strobe; data is expected on `mem_rdata` in the next cycle |
| mem_wr | output | 1 | Write strobe; the memory writes at this clock edge |
| mem_pd | output | 1 | Presence-detect strobe; the top address is expected in the next cycle |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data from memory |
| in_valid | input | 1 | Input value offered |
| in_ready | output | 1 | Core is waiting for an input value |
| in_data | input | DATA_W | Input value |
| out_valid | output | 1 | One-cycle output strobe |
| out_data | output | DATA_W | Accumulator value for the output strobe |
| halted | output | 1 | Core is stopped by a halt instruction |
| mcheck | output | 1 | Sticky arithmetic overflow machine check |

## Verification
The bound checker watches some properties on every cycle:
- reads and writes are never issued together;
- every read is followed by a quiet wait cycle;
- the program counter steps by one in the fetch wait;
- the output strobe lasts exactly one cycle;
- the input wait holds until a value arrives;
- presence detect leads to the write of the top word two cycles later;
- the halt and machine-check outputs never drop before reset.

Other behaviour can only be shown by the bench's scenarios, run against a behavioural reference:
- the exact cycle of every memory access;
- the taken and not-taken branch lengths;
- the truncated overflow result;
- the order of output values;
- that stray input offers are ignored.

// File: rtl/acc12_pkg.sv
package acc12_pkg;

   // Sequencer phases: three init steps, three fetch steps, up to three execute steps
   typedef enum logic [3:0] {
      PH_PD, PH_PDW, PH_INIT,
      PH_F0, PH_F1, PH_F2,
      PH_E0, PH_E1, PH_E2,
      PH_HALT
   } phase_e;

   // Decoded instruction class; conditional branches resolve to K_JMP or K_NOP
   typedef enum logic [3:0] {
      K_NOP, K_HLT, K_ADD, K_SUB, K_LDA, K_STO, K_JMP, K_IN, K_OUT
   } kind_e;

   typedef enum logic [1:0] {
      ASEL_MDR, ASEL_PC, ASEL_IRA, ASEL_IN
   } asel_e;

   typedef struct packed {
      logic ena_a;
      logic inv_a;
      logic ena_b;
      logic inc;
   } alu_ctl_t;

   localparam alu_ctl_t CTL_ZERO   = '{ena_a: 1'b0, inv_a: 1'b0, ena_b: 1'b0, inc: 1'b0};
   localparam alu_ctl_t CTL_PASS_A = '{ena_a: 1'b1, inv_a: 1'b0, ena_b: 1'b0, inc: 1'b0};
   localparam alu_ctl_t CTL_PASS_B = '{ena_a: 1'b0, inv_a: 1'b0, ena_b: 1'b1, inc: 1'b0};
   localparam alu_ctl_t CTL_INC_A  = '{ena_a: 1'b1, inv_a: 1'b0, ena_b: 1'b0, inc: 1'b1};
   localparam alu_ctl_t CTL_ADD    = '{ena_a: 1'b1, inv_a: 1'b0, ena_b: 1'b1, inc: 1'b0};
   localparam alu_ctl_t CTL_SUB    = '{ena_a: 1'b1, inv_a: 1'b1, ena_b: 1'b1, inc: 1'b1};

   localparam int OPC_W = 4;
   localparam logic [OPC_W-1:0] OPC_HLT = 4'd0;
   localparam logic [OPC_W-1:0] OPC_ADD = 4'd1;
   localparam logic [OPC_W-1:0] OPC_SUB = 4'd2;
   localparam logic [OPC_W-1:0] OPC_STO = 4'd3;
   localparam logic [OPC_W-1:0] OPC_LDA = 4'd5;
   localparam logic [OPC_W-1:0] OPC_BR  = 4'd6;
   localparam logic [OPC_W-1:0] OPC_BRZ = 4'd7;
   localparam logic [OPC_W-1:0] OPC_BRP = 4'd8;
   localparam logic [OPC_W-1:0] OPC_IO  = 4'd9;
   localparam int IO_SUB_IN  = 1;
   localparam int IO_SUB_OUT = 2;

endpackage

// File: rtl/acc12_alu.sv
module acc12_alu
   import acc12_pkg::*;
#(
   parameter int  W      = 12,
   parameter bit  RIPPLE = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_ctl_t     ctl,
   output logic [W-1:0] y,
   output logic         ovf,
   output logic         pos,
   output logic         zero
);

   initial begin
      if (W < 2) $error("acc12_alu: W must be at least 2");
   end

   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0]   cy;
         logic [W-1:0] ae;
         logic [W-1:0] be;
         assign cy[0] = ctl.inc;
         for (genvar i = 0; i < W; i++) begin : g_slice
            assign ae[i]   = (a[i] & ctl.ena_a) ^ ctl.inv_a;
            assign be[i]   = b[i] & ctl.ena_b;
            assign y[i]    = ae[i] ^ be[i] ^ cy[i];
            assign cy[i+1] = (ae[i] & be[i]) | (cy[i] & (ae[i] ^ be[i]));
         end
         assign ovf = cy[W] ^ cy[W-1];
      end else begin : g_flat
         logic [W-1:0] ae;
         logic [W-1:0] be;
         assign ae  = (a & {W{ctl.ena_a}}) ^ {W{ctl.inv_a}};
         assign be  = b & {W{ctl.ena_b}};
         assign y   = ae + be + W'(ctl.inc);
         assign ovf = (ae[W-1] == be[W-1]) && (y[W-1] != ae[W-1]);
      end
   endgenerate

   assign pos  = ~y[W-1];
   assign zero = ~|y;

endmodule

// File: rtl/acc12_seq.sv
module acc12_seq
   import acc12_pkg::*;
#(
   parameter int OP_W   = 4,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OP_W-1:0]   dec_op,
   input  logic [ADDR_W-1:0] dec_arg,
   input  logic              flag_p,
   input  logic              flag_z,
   input  logic              in_valid,
   output phase_e            phase,
   output kind_e             kind
);

   kind_e  kind_d;
   phase_e phase_d;

   // Classify the word held in the data register during the last fetch step
   always_comb begin
      case (dec_op)
         OPC_HLT: kind_d = K_HLT;
         OPC_ADD: kind_d = K_ADD;
         OPC_SUB: kind_d = K_SUB;
         OPC_LDA: kind_d = K_LDA;
         OPC_STO: kind_d = K_STO;
         OPC_BR:  kind_d = K_JMP;
         OPC_BRZ: kind_d = flag_z ? K_JMP : K_NOP;
         OPC_BRP: kind_d = flag_p ? K_JMP : K_NOP;
         OPC_IO: begin
            if (dec_arg == ADDR_W'(IO_SUB_IN))       kind_d = K_IN;
            else if (dec_arg == ADDR_W'(IO_SUB_OUT)) kind_d = K_OUT;
            else                                     kind_d = K_NOP;
         end
         default: kind_d = K_NOP;
      endcase
   end

   always_comb begin
      phase_d = phase;
      case (phase)
         PH_PD:   phase_d = PH_PDW;
         PH_PDW:  phase_d = PH_INIT;
         PH_INIT: phase_d = PH_F0;
         PH_F0:   phase_d = PH_F1;
         PH_F1:   phase_d = PH_F2;
         PH_F2: begin
            if (kind_d == K_HLT)      phase_d = PH_HALT;
            else if (kind_d == K_NOP) phase_d = PH_F0;
            else                      phase_d = PH_E0;
         end
         PH_E0: begin
            case (kind)
               K_JMP, K_OUT: phase_d = PH_F0;
               K_IN:         phase_d = in_valid ? PH_F0 : PH_E0;
               default:      phase_d = PH_E1;
            endcase
         end
         PH_E1:   phase_d = PH_E2;
         PH_E2:   phase_d = PH_F0;
         default: phase_d = PH_HALT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_PD;
         kind  <= K_NOP;
      end else begin
         phase <= phase_d;
         if (phase == PH_F2) kind <= kind_d;
      end
   end

endmodule

// File: rtl/acc12_core.sv
module acc12_core
   import acc12_pkg::*;
#(
   parameter int DATA_W     = 12,
   parameter int OP_W       = 4,
   parameter int ADDR_W     = 8,
   parameter bit RIPPLE_ALU = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              mem_pd,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              halted,
   output logic              mcheck
);

   localparam int OP_LSB = DATA_W - OP_W;

   if (DATA_W != OP_W + ADDR_W) begin : g_bad_format
      $error("acc12_core: DATA_W must equal OP_W + ADDR_W");
   end
   if (OP_W != OPC_W) begin : g_bad_opw
      $error("acc12_core: opcode field must match the package opcode width");
   end

   logic [ADDR_W-1:0] pc_q, mar_q, ira_q;
   logic [DATA_W-1:0] mdr_q, acc_q;
   logic              p_q, z_q, mchk_q;

   phase_e   phase;
   kind_e    kind;
   asel_e    asel;
   alu_ctl_t actl;
   logic [DATA_W-1:0] abus, cbus;
   logic alu_ovf, alu_pos, alu_zero;
   logic ld_pc, ld_mar, ld_mdr_mem, ld_mdr_c, ld_ira, ld_acc, chk_ovf;

   acc12_seq #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .dec_op   (mdr_q[DATA_W-1:OP_LSB]),
      .dec_arg  (mdr_q[ADDR_W-1:0]),
      .flag_p   (p_q),
      .flag_z   (z_q),
      .in_valid (in_valid),
      .phase    (phase),
      .kind     (kind)
   );

   // A-bus source selection; the B-bus is the accumulator
   always_comb begin
      case (asel)
         ASEL_PC:  abus = DATA_W'(pc_q);
         ASEL_IRA: abus = DATA_W'(ira_q);
         ASEL_IN:  abus = in_data;
         default:  abus = mdr_q;
      endcase
   end

   acc12_alu #(.W(DATA_W), .RIPPLE(RIPPLE_ALU)) u_alu (
      .a    (abus),
      .b    (acc_q),
      .ctl  (actl),
      .y    (cbus),
      .ovf  (alu_ovf),
      .pos  (alu_pos),
      .zero (alu_zero)
   );

   // Per-phase control word
   always_comb begin
      asel       = ASEL_MDR;
      actl       = CTL_ZERO;
      mem_rd     = 1'b0;
      mem_wr     = 1'b0;
      mem_pd     = 1'b0;
      ld_pc      = 1'b0;
      ld_mar     = 1'b0;
      ld_mdr_mem = 1'b0;
      ld_mdr_c   = 1'b0;
      ld_ira     = 1'b0;
      ld_acc     = 1'b0;
      chk_ovf    = 1'b0;
      in_ready   = 1'b0;
      out_valid  = 1'b0;
      case (phase)
         PH_PD:   mem_pd = 1'b1;
         PH_PDW:  ld_mdr_mem = 1'b1;
         PH_INIT: begin
            actl   = CTL_PASS_A;
            ld_mar = 1'b1;
            mem_wr = 1'b1;
         end
         PH_F0: begin
            asel   = ASEL_PC;
            actl   = CTL_PASS_A;
            ld_mar = 1'b1;
            mem_rd = 1'b1;
         end
         PH_F1: begin
            asel       = ASEL_PC;
            actl       = CTL_INC_A;
            ld_pc      = 1'b1;
            ld_mdr_mem = 1'b1;
         end
         PH_F2: ld_ira = 1'b1;
         PH_E0: begin
            case (kind)
               K_ADD, K_SUB, K_LDA: begin
                  asel   = ASEL_IRA;
                  actl   = CTL_PASS_A;
                  ld_mar = 1'b1;
                  mem_rd = 1'b1;
               end
               K_STO: begin
                  asel   = ASEL_IRA;
                  actl   = CTL_PASS_A;
                  ld_mar = 1'b1;
               end
               K_JMP: begin
                  asel  = ASEL_IRA;
                  actl  = CTL_PASS_A;
                  ld_pc = 1'b1;
               end
               K_IN: begin
                  asel     = ASEL_IN;
                  actl     = CTL_PASS_A;
                  in_ready = 1'b1;
                  ld_acc   = in_valid;
               end
               K_OUT:   out_valid = 1'b1;
               default: ;
            endcase
         end
         PH_E1: begin
            case (kind)
               K_ADD, K_SUB, K_LDA: ld_mdr_mem = 1'b1;
               K_STO: begin
                  actl     = CTL_PASS_B;
                  ld_mdr_c = 1'b1;
                  mem_wr   = 1'b1;
               end
               default: ;
            endcase
         end
         PH_E2: begin
            case (kind)
               K_ADD: begin
                  actl    = CTL_ADD;
                  ld_acc  = 1'b1;
                  chk_ovf = 1'b1;
               end
               K_SUB: begin
                  actl    = CTL_SUB;
                  ld_acc  = 1'b1;
                  chk_ovf = 1'b1;
               end
               K_LDA: begin
                  actl   = CTL_PASS_A;
                  ld_acc = 1'b1;
               end
               default: ;
            endcase
         end
         default: ;
      endcase
   end

   assign mem_addr  = ld_mar ? cbus[ADDR_W-1:0] : mar_q;
   assign mem_wdata = cbus;
   assign out_data  = acc_q;
   assign halted    = (phase == PH_HALT);
   assign mcheck    = mchk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= '0;
         mar_q  <= '0;
         ira_q  <= '0;
         mdr_q  <= '0;
         acc_q  <= '0;
         p_q    <= 1'b1;
         z_q    <= 1'b1;
         mchk_q <= 1'b0;
      end else begin
         if (ld_pc)  pc_q  <= cbus[ADDR_W-1:0];
         if (ld_mar) mar_q <= cbus[ADDR_W-1:0];
         if (ld_ira) ira_q <= mdr_q[ADDR_W-1:0];
         if (ld_mdr_mem)    mdr_q <= mem_rdata;
         else if (ld_mdr_c) mdr_q <= cbus;
         if (ld_acc) begin
            acc_q <= cbus;
            p_q   <= alu_pos;
            z_q   <= alu_zero;
         end
         if (chk_ovf && alu_ovf) mchk_q <= 1'b1;
      end
   end

endmodule

// File: rtl/acc12_core_chk.sv
module acc12_core_chk
   import acc12_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              mem_pd,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic              halted,
   input logic              mcheck,
   input phase_e            phase,
   input logic [ADDR_W-1:0] pc
);

   p_pd_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_pd |=> !mem_pd);

   p_pd_then_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_pd |-> ##2 mem_wr);

   p_rd_wr_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   p_read_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> (!mem_rd && !mem_wr));

   p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_F1) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

   p_mchk_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mcheck |=> mcheck);

   p_in_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> in_ready);

   p_out_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!mem_rd && !mem_wr && !out_valid && !in_ready));

endmodule

bind acc12_core acc12_core_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .mem_pd    (mem_pd),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .halted    (halted),
   .mcheck    (mcheck),
   .phase     (phase),
   .pc        (pc_q)
);

// File: tb/acc12_core_test.sv
module acc12_core_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  mem_addr;
   logic        mem_rd, mem_wr, mem_pd;
   logic [11:0] mem_wdata;
   logic [11:0] rdata_q = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [11:0] in_data = '0;
   logic        out_valid;
   logic [11:0] out_data;
   logic        halted, mcheck;

   always #4 clk = ~clk;   // 8 ns period, 125 MHz

   acc12_core uut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_pd(mem_pd), .mem_wdata(mem_wdata), .mem_rdata(rdata_q), .in_valid(in_valid),
      .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
      .halted(halted), .mcheck(mcheck)
   );

   // Environment memory: 128 words, registered read, top address on presence detect
   logic [11:0] mem [0:127];
   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr[6:0]] <= mem_wdata;
      if (mem_rd)      rdata_q <= mem[mem_addr[6:0]];
      else if (mem_pd) rdata_q <= 12'd127;
   end

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string what, input logic [11:0] act, input logic [11:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   // Behavioural reference: per-instruction cycle counter and architectural state
   int          k = -3;
   int          rpc = 0;
   int          stall = 0;
   int          cyc = 0;
   logic [11:0] racc = '0;
   logic [11:0] ins = '0;
   logic [11:0] in_value = 12'd100;
   bit          rhalt = 1'b0;
   bit          rmch = 1'b0;
   logic [11:0] rmem [0:127];
   logic [11:0] outs [$];

   always @(negedge clk) begin
      bit e_rd, e_wr, e_pd, e_ov, e_ir;
      logic [7:0]  e_addr;
      logic [11:0] e_wd, m;
      logic [3:0]  op;
      string tag;
      int s;
      cyc++;
      e_rd = 0; e_wr = 0; e_pd = 0; e_ov = 0; e_ir = 0; e_addr = '0; e_wd = '0;
      if (!rst_n) begin
         chk(!halted && !mcheck && !out_valid, "R1 reset outputs", {9'b0, halted, mcheck, out_valid}, 12'h000);
         k = -3; rpc = 0; racc = '0; rhalt = 0; rmch = 0; stall = 0;
         in_valid = 1'b0;
      end else begin
         tag = "R2";
         op = ins[3+8:8];
         // Drive input: real value after two stall cycles, stray offers otherwise (R9: ignored)
         in_valid = 1'b0;
         in_data  = 12'hABC;
         if (!rhalt && k == 3 && op == 4'd9 && ins[7:0] == 8'd1) begin
            if (stall >= 2) begin
               in_valid = 1'b1;
               in_data  = in_value;
            end else stall++;
         end else if (cyc % 5 == 0) in_valid = 1'b1;

         chk(halted == rhalt, "R11 halted", {11'b0, halted}, {11'b0, rhalt});
         chk(mcheck == rmch, "R3 mcheck", {11'b0, mcheck}, {11'b0, rmch});
         if (out_valid) outs.push_back(out_data);

         if (rhalt) tag = "R11";
         else begin
            case (k)
               -3: begin e_pd = 1; tag = "R1"; k = -2; end
               -2: begin tag = "R1"; k = -1; end
               -1: begin
                  tag = "R1"; e_wr = 1; e_addr = 8'd127; e_wd = 12'd127;
                  rmem[127] = 12'd127; k = 0;
               end
               0: begin
                  e_rd = 1; e_addr = 8'(rpc); ins = rmem[rpc[6:0]];
                  rpc = (rpc + 1) % 256; k = 1;
               end
               1: k = 2;
               2: begin
                  case (op)
                     4'd0: begin rhalt = 1; tag = "R11"; end
                     4'd1, 4'd2, 4'd3, 4'd5, 4'd6: k = 3;
                     4'd7: begin tag = "R7"; k = (racc == 0) ? 3 : 0; end
                     4'd8: begin tag = "R8"; k = (racc[11] == 1'b0) ? 3 : 0; end
                     4'd9: begin tag = "R12"; k = (ins[7:0] == 8'd1 || ins[7:0] == 8'd2) ? 3 : 0; end
                     default: begin tag = "R12"; k = 0; end
                  endcase
               end
               3: begin
                  case (op)
                     4'd1, 4'd2, 4'd5: begin tag = "R3"; e_rd = 1; e_addr = ins[7:0]; k = 4; end
                     4'd3: begin tag = "R5"; k = 4; end
                     4'd6, 4'd7, 4'd8: begin tag = "R6"; rpc = ins[7:0]; k = 0; end
                     default: begin
                        if (ins[7:0] == 8'd2) begin tag = "R10"; e_ov = 1; k = 0; end
                        else begin
                           tag = "R9"; e_ir = 1;
                           if (in_valid) begin racc = in_data; k = 0; stall = 0; end
                        end
                     end
                  endcase
               end
               4: begin
                  k = 5;
                  if (op == 4'd3) begin
                     tag = "R5"; e_wr = 1; e_addr = ins[7:0]; e_wd = racc;
                     rmem[ins[6:0]] = racc;
                  end
               end
               default: begin
                  m = rmem[ins[6:0]];
                  tag = "R4";
                  if (op == 4'd1 || op == 4'd2) begin
                     tag = "R3";
                     s = (op == 4'd1) ? $signed(racc) + $signed(m) : $signed(racc) - $signed(m);
                     if (s > 2047 || s < -2048) rmch = 1;
                     racc = 12'(s);
                  end else if (op == 4'd5) racc = m;
                  k = 0;
               end
            endcase
         end
         chk(mem_pd == e_pd, {tag, " mem_pd"}, {11'b0, mem_pd}, {11'b0, e_pd});
         chk(mem_rd == e_rd, {tag, " mem_rd"}, {11'b0, mem_rd}, {11'b0, e_rd});
         chk(mem_wr == e_wr, {tag, " mem_wr"}, {11'b0, mem_wr}, {11'b0, e_wr});
         chk(out_valid == e_ov, {tag, " out_valid"}, {11'b0, out_valid}, {11'b0, e_ov});
         chk(in_ready == e_ir, {tag, " in_ready"}, {11'b0, in_ready}, {11'b0, e_ir});
         if (e_rd || e_wr) chk(mem_addr == e_addr, {tag, " mem_addr"}, {4'b0, mem_addr}, {4'b0, e_addr});
         if (e_wr) chk(mem_wdata == e_wd, {tag, " mem_wdata"}, mem_wdata, e_wd);
         if (e_ov) chk(out_data == racc, {tag, " out_data"}, out_data, racc);
      end
   end

   task automatic put(input int a, input logic [11:0] w);
      mem[a] = w;
      rmem[a] = w;
   endtask

   bit timeout = 1'b0;

   task automatic run_to_halt();
      int n;
      n = 0;
      while (!halted && n < 3000) begin
         @(posedge clk);
         n++;
      end
      if (!halted) timeout = 1'b1;
   endtask

   initial begin
      logic [11:0] exp_outs [6];
      exp_outs = '{12'h064, 12'hFCE, 12'h800, 12'h007, 12'hF71, 12'h800};
      for (int i = 0; i < 128; i++) put(i, 12'h000);
      put(8'h00, 12'h901); put(8'h01, 12'h902); put(8'h02, 12'h140); put(8'h03, 12'h241);
      put(8'h04, 12'h902); put(8'h05, 12'h808); put(8'h06, 12'h342); put(8'h07, 12'h543);
      put(8'h08, 12'h70A); put(8'h09, 12'h000); put(8'h0A, 12'h80C); put(8'h0B, 12'h000);
      put(8'h0C, 12'h544); put(8'h0D, 12'h145); put(8'h0E, 12'h902); put(8'h0F, 12'h712);
      put(8'h10, 12'h400); put(8'h11, 12'h905); put(8'h12, 12'hF00); put(8'h13, 12'h615);
      put(8'h14, 12'h000); put(8'h15, 12'h346); put(8'h16, 12'h000);
      put(8'h40, 12'd50); put(8'h41, 12'd200); put(8'h43, 12'd0);
      put(8'h44, 12'h7FF); put(8'h45, 12'd1);

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      run_to_halt();
      repeat (4) @(posedge clk);
      #1 chk(mcheck == 1'b1, "R3 mcheck sticky after overflow", {11'b0, mcheck}, 12'h001);
      chk(mem[8'h42] == 12'hFCE, "R5 stored difference", mem[8'h42], 12'hFCE);

      // Second run: reset must clear the machine check and restart at 0
      @(posedge clk); #1 rst_n = 1'b0; in_value = 12'd7;
      repeat (2) @(posedge clk);
      #1 chk(mcheck == 1'b0, "R3 mcheck cleared by reset", {11'b0, mcheck}, 12'h000);
      rst_n = 1'b1;
      if (!timeout) run_to_halt();
      repeat (3) @(posedge clk);
      #1;
      chk(mem[8'h42] == 12'hF71, "R5 stored difference run 2", mem[8'h42], 12'hF71);
      chk(mem[8'h46] == 12'h800, "R3 truncated overflow stored", mem[8'h46], 12'h800);
      chk(mem[8'h7F] == 12'h07F, "R1 top word self-address", mem[8'h7F], 12'h07F);
      chk(mem[8'h09] == 12'h000 && mem[8'h14] == 12'h000, "R6 skipped words untouched", mem[8'h14], 12'h000);
      chk(outs.size() == 6, "R10 output count", 12'(outs.size()), 12'd6);
      for (int i = 0; i < 6; i++)
         if (i < outs.size()) chk(outs[i] == exp_outs[i], "R10 R13 output value", outs[i], exp_outs[i]);
      if (timeout) begin
         n_chk++; n_fail++;
         $display("FAIL R11 watchdog: no halt actual=%h expected=%h", 12'h000, 12'h001);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule